// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File with Paired Mode

This block holds the floating-point general registers of a processor core: a parameterised number of 64-bit entries, one read port and one write port. Every access carries a format code. Each register keeps a tag that records the format it was last written or first read with. A read that conflicts with the tag returns a quiet-NaN pattern chosen by the requested format, and that register stays poisoned until it is written again.

An input selects the register model. In wide mode every register holds a full 64-bit value. In narrow mode registers are 32 bits each, and a 64-bit value occupies an even/odd pair. The upper half of the value sits in the odd register. A 64-bit access that names an odd register raises a reserved-instruction pulse. An unsupported format code raises a separate fault pulse.

Reads are synchronous. The data, the exception pulse and the fault pulse appear one cycle after the request. Tag changes caused by a read take effect at that same edge.

Top module: `fpr_tag_file`

## Requirements
- R1: After reset every register holds zero and every tag is uninterpreted, so a first read of any register in any supported format returns zero.
- R2: A read with format single (code 0) or word (code 1) returns the low 32 bits of the register, zero-extended, in either mode.
- R3: In narrow mode (mode_wide=0), a 64-bit read of even register N returns register N+1's low half as bits 63:32 and register N's low half as bits 31:0. The 64-bit formats are double (2), long (3) and uninterpreted (4). A 64-bit write to even N stores bits 63:32 in N+1 and bits 31:0 in N.
- R4: In narrow mode, a 64-bit access to an odd register pulses rsvd_exc one cycle later and moves no data. Such a read returns zero. Such a write tags that register and the next one (if it exists) as unknown.
- R5: An uninterpreted read (code 4) is checked against the register's current tag and returns the raw 64-bit view: the full register in wide mode, or the pair in narrow mode. A register still tagged uninterpreted adopts the format of its first single, word, double or long read.
- R6: A single, word, double or long read whose format differs from a known tag changes that tag to unknown. Later reads of that register return quiet NaNs until it is written.
- R7: A read that conflicts, or that hits an unknown tag, returns the quiet NaN for the requested format: 0x7FBFFFFF (single), 0x7FFFFFFF (word), 0x7FF7FFFFFFFFFFFF (double), 0x7FFFFFFFFFFFFFFF (long).
- R8: In wide mode a single or word write stores the value in bits 31:0 and the fill word 0xDEADC0DE in bits 63:32.
- R9: A write sets the tag to the written format. In narrow mode a 64-bit write to even N sets the tags of both N and N+1.
- R10: A read and a write issued in the same cycle return the old contents. When both touch the same register's tag, the write's tag wins.
- R11: A format code of 5 to 7 on either port pulses fmt_fault and changes no register or tag. An uninterpreted read of an unknown-tagged register also pulses fmt_fault and returns zero.
- R12: rd_valid is high exactly in the cycle after a cycle with rd_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 1: 64-bit registers; 0: 32-bit registers paired for 64-bit values |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read register number |
| rd_fmt | input | 3 | Read format code |
| rd_data | output | 64 | Read result, one cycle after the request |
| rd_valid | output | 1 | rd_data holds a fresh result |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write register number |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write value |
| rsvd_exc | output | 1 | Odd-register 64-bit access in narrow mode (one-cycle pulse) |
| fmt_fault | output | 1 | Unsupported format, or uninterpreted read of unknown tag (pulse) |

## Verification
The bench builds the block with its defaults: 32 registers and the standard fill word. These settings put the last register, number 31, within reach. An odd pair write there has no partner to poison, which exercises the edge of the pair logic. The fill word is observed through uninterpreted reads in wide mode. Directed sequences switch between the two modes on the same storage. They walk registers through adoption, conflict and poisoning, and then recovery by a fresh write. They also place a read and a write in the same cycle on one register.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
   localparam logic [2:0] FMT_SINGLE = 3'd0;
   localparam logic [2:0] FMT_WORD   = 3'd1;
   localparam logic [2:0] FMT_DOUBLE = 3'd2;
   localparam logic [2:0] FMT_LONG   = 3'd3;
   localparam logic [2:0] FMT_RAW    = 3'd4;
   localparam logic [2:0] TAG_UNK    = 3'd7;

   localparam logic [63:0] QNAN_SINGLE = 64'h0000_0000_7FBF_FFFF;
   localparam logic [63:0] QNAN_WORD   = 64'h0000_0000_7FFF_FFFF;
   localparam logic [63:0] QNAN_DOUBLE = 64'h7FF7_FFFF_FFFF_FFFF;
   localparam logic [63:0] QNAN_LONG   = 64'h7FFF_FFFF_FFFF_FFFF;

   function automatic logic fmt_ok(input logic [2:0] f);
      return f <= FMT_RAW;
   endfunction

   function automatic logic fmt_is64(input logic [2:0] f);
      return (f == FMT_DOUBLE) || (f == FMT_LONG) || (f == FMT_RAW);
   endfunction

   function automatic logic [63:0] qnan_for(input logic [2:0] f);
      case (f)
         FMT_SINGLE: return QNAN_SINGLE;
         FMT_WORD:   return QNAN_WORD;
         FMT_DOUBLE: return QNAN_DOUBLE;
         default:    return QNAN_LONG;
      endcase
   endfunction
endpackage

// File: rtl/fpr_read_ctl.sv
module fpr_read_ctl
   import fpr_pkg::*;
(
   input  logic        mode_wide,
   input  logic        idx_odd,
   input  logic [2:0]  fmt,
   input  logic [2:0]  tag_cur,
   input  logic [63:0] lo_reg,
   input  logic [63:0] hi_reg,
   output logic [63:0] data,
   output logic        tag_we,
   output logic [2:0]  tag_new,
   output logic        rsvd,
   output logic        fault
);
   always_comb begin
      data    = '0;
      tag_we  = 1'b0;
      tag_new = tag_cur;
      rsvd    = 1'b0;
      fault   = 1'b0;
      if (!fmt_ok(fmt)) begin
         fault = 1'b1;
      end else if (tag_cur == TAG_UNK) begin
         if (fmt == FMT_RAW) fault = 1'b1;
         else                data  = qnan_for(fmt);
      end else if (tag_cur != FMT_RAW && fmt != FMT_RAW && fmt != tag_cur) begin
         tag_we  = 1'b1;
         tag_new = TAG_UNK;
         data    = qnan_for(fmt);
      end else begin
         if (tag_cur == FMT_RAW && fmt != FMT_RAW) begin
            tag_we  = 1'b1;
            tag_new = fmt;
         end
         if (!fmt_is64(fmt))  data = {32'h0, lo_reg[31:0]};
         else if (mode_wide)  data = lo_reg;
         else if (!idx_odd)   data = {hi_reg[31:0], lo_reg[31:0]};
         else                 rsvd = 1'b1;
      end
   end
endmodule

// File: rtl/fpr_write_ctl.sv
module fpr_write_ctl
   import fpr_pkg::*;
#(
   parameter logic [31:0] FILL_WORD = 32'hDEAD_C0DE
)(
   input  logic        en,
   input  logic        mode_wide,
   input  logic        idx_odd,
   input  logic        has_next,
   input  logic [2:0]  fmt,
   input  logic [63:0] wdata,
   output logic        dwe_a,
   output logic        dwe_b,
   output logic [63:0] data_a,
   output logic [63:0] data_b,
   output logic        twe_a,
   output logic        twe_b,
   output logic [2:0]  tag_a,
   output logic [2:0]  tag_b,
   output logic        rsvd,
   output logic        fault
);
   always_comb begin
      dwe_a = 1'b0; dwe_b = 1'b0;
      twe_a = 1'b0; twe_b = 1'b0;
      data_a = '0;  data_b = '0;
      tag_a = fmt;  tag_b = fmt;
      rsvd = 1'b0;  fault = 1'b0;
      if (en) begin
         if (!fmt_ok(fmt)) begin
            fault = 1'b1;
         end else if (!fmt_is64(fmt)) begin
            dwe_a  = 1'b1;
            twe_a  = 1'b1;
            data_a = mode_wide ? {FILL_WORD, wdata[31:0]} : {32'h0, wdata[31:0]};
         end else if (mode_wide) begin
            dwe_a  = 1'b1;
            twe_a  = 1'b1;
            data_a = wdata;
         end else if (!idx_odd) begin
            dwe_a  = 1'b1; dwe_b = 1'b1;
            twe_a  = 1'b1; twe_b = 1'b1;
            data_a = {32'h0, wdata[31:0]};
            data_b = {32'h0, wdata[63:32]};
         end else begin
            rsvd  = 1'b1;
            twe_a = 1'b1;
            tag_a = TAG_UNK;
            twe_b = has_next;
            tag_b = TAG_UNK;
         end
      end
   end
endmodule

// File: rtl/fpr_tag_file.sv
module fpr_tag_file
   import fpr_pkg::*;
#(
   parameter int          NREGS     = 32,
   parameter logic [31:0] FILL_WORD = 32'hDEAD_C0DE,
   localparam int         IDX_W     = $clog2(NREGS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wide,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [2:0]       rd_fmt,
   output logic [63:0]      rd_data,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [2:0]       wr_fmt,
   input  logic [63:0]      wr_data,
   output logic             rsvd_exc,
   output logic             fmt_fault
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);

   generate
      if (NREGS < 2 || (1 << IDX_W) != NREGS) begin : g_bad_nregs
         $error("NREGS must be a power of two, at least 2");
      end
   endgenerate

   logic [63:0] reg_arr [NREGS];
   logic [2:0]  tag_arr [NREGS];

   logic [63:0] rc_data;
   logic        rc_twe, rc_rsvd, rc_fault;
   logic [2:0]  rc_tag;

   fpr_read_ctl u_rd (
      .mode_wide (mode_wide),
      .idx_odd   (rd_idx[0]),
      .fmt       (rd_fmt),
      .tag_cur   (tag_arr[rd_idx]),
      .lo_reg    (reg_arr[rd_idx]),
      .hi_reg    (reg_arr[rd_idx | IDX_W'(1)]),
      .data      (rc_data),
      .tag_we    (rc_twe),
      .tag_new   (rc_tag),
      .rsvd      (rc_rsvd),
      .fault     (rc_fault)
   );

   logic        w_dwe_a, w_dwe_b, w_twe_a, w_twe_b, w_rsvd, w_fault;
   logic [63:0] w_data_a, w_data_b;
   logic [2:0]  w_tag_a, w_tag_b;
   logic [IDX_W-1:0] wr_idx_b;
   assign wr_idx_b = wr_idx + IDX_W'(1);

   fpr_write_ctl #(.FILL_WORD(FILL_WORD)) u_wr (
      .en        (wr_en),
      .mode_wide (mode_wide),
      .idx_odd   (wr_idx[0]),
      .has_next  (wr_idx != LAST_IDX),
      .fmt       (wr_fmt),
      .wdata     (wr_data),
      .dwe_a     (w_dwe_a),
      .dwe_b     (w_dwe_b),
      .data_a    (w_data_a),
      .data_b    (w_data_b),
      .twe_a     (w_twe_a),
      .twe_b     (w_twe_b),
      .tag_a     (w_tag_a),
      .tag_b     (w_tag_b),
      .rsvd      (w_rsvd),
      .fault     (w_fault)
   );

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         localparam logic [IDX_W-1:0] MY = IDX_W'(i);
         logic [63:0] q;
         logic [2:0]  t;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
               t <= FMT_RAW;
            end else begin
               if (w_dwe_a && wr_idx == MY)        q <= w_data_a;
               else if (w_dwe_b && wr_idx_b == MY) q <= w_data_b;
               if (w_twe_a && wr_idx == MY)        t <= w_tag_a;
               else if (w_twe_b && wr_idx_b == MY) t <= w_tag_b;
               else if (rd_en && rc_twe && rd_idx == MY) t <= rc_tag;
            end
         end
         assign reg_arr[i] = q;
         assign tag_arr[i] = t;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         rd_valid  <= 1'b0;
         rsvd_exc  <= 1'b0;
         fmt_fault <= 1'b0;
      end else begin
         rd_valid  <= rd_en;
         if (rd_en) rd_data <= rc_data;
         rsvd_exc  <= (rd_en && rc_rsvd) || w_rsvd;
         fmt_fault <= (rd_en && rc_fault) || w_fault;
      end
   end

   p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_valid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   p_rsvd_narrow_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_exc |-> $past(!mode_wide));
   p_narrow_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_fmt == FMT_SINGLE || rd_fmt == FMT_WORD))
      |-> rd_data[63:32] == 32'h0);
   p_fault_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_fault |-> $past((rd_en && rd_fmt >= FMT_RAW) || (wr_en && wr_fmt > FMT_RAW)));
endmodule

// File: tb/sim_fpr_tag_file.sv
module sim_fpr_tag_file;
   import fpr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wide = 1'b1;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_idx = '0;
   logic [2:0]  rd_fmt = '0;
   logic [63:0] rd_data;
   logic        rd_valid;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [2:0]  wr_fmt = '0;
   logic [63:0] wr_data = '0;
   logic        rsvd_exc, fmt_fault;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   fpr_tag_file u0 (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_read(input logic [4:0] idx, input logic [2:0] fmt,
                          input logic [63:0] exp, input logic er, input logic ef,
                          input string req);
      @(negedge clk);
      rd_en = 1'b1; rd_idx = idx; rd_fmt = fmt;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      chk({req, " valid"}, 64'(rd_valid), 64'd1);
      chk({req, " data"}, rd_data, exp);
      chk({req, " rsvd"}, 64'(rsvd_exc), 64'(er));
      chk({req, " fault"}, 64'(fmt_fault), 64'(ef));
   endtask

   task automatic do_write(input logic [4:0] idx, input logic [2:0] fmt,
                           input logic [63:0] d, input logic er, input logic ef,
                           input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_fmt = fmt; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      chk({req, " rsvd"}, 64'(rsvd_exc), 64'(er));
      chk({req, " fault"}, 64'(fmt_fault), 64'(ef));
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 fault idle", 64'(fmt_fault), 64'd0);
      do_read(5'd5, FMT_LONG, 64'h0, 0, 0, "R1 long");
      do_read(5'd6, FMT_SINGLE, 64'h0, 0, 0, "R1 single");
      do_read(5'd7, FMT_RAW, 64'h0, 0, 0, "R1 raw");
      @(negedge clk);
      chk("R12 valid drops", 64'(rd_valid), 64'd0);
   endtask

   task automatic t_wide_single();
      do_reset();
      mode_wide = 1'b1;
      do_write(5'd2, FMT_SINGLE, 64'hAAAA_AAAA_3F80_0000, 0, 0, "R9 wr single");
      do_read(5'd2, FMT_SINGLE, 64'h0000_0000_3F80_0000, 0, 0, "R2 single");
      do_read(5'd2, FMT_RAW, 64'hDEAD_C0DE_3F80_0000, 0, 0, "R8 fill");
      do_read(5'd2, FMT_DOUBLE, QNAN_DOUBLE, 0, 0, "R6 conflict");
      do_read(5'd2, FMT_SINGLE, QNAN_SINGLE, 0, 0, "R7 qnan single");
      do_read(5'd2, FMT_WORD, QNAN_WORD, 0, 0, "R7 qnan word");
      do_read(5'd2, FMT_LONG, QNAN_LONG, 0, 0, "R7 qnan long");
      do_read(5'd2, FMT_RAW, 64'h0, 0, 1, "R11 raw on unknown");
      do_write(5'd2, FMT_LONG, 64'h0123_4567_89AB_CDEF, 0, 0, "R9 rewrite");
      do_read(5'd2, FMT_LONG, 64'h0123_4567_89AB_CDEF, 0, 0, "R9 recovered");
      do_write(5'd10, FMT_DOUBLE, 64'h4009_21FB_5444_2D18, 0, 0, "R9 wr double");
      do_read(5'd10, FMT_RAW, 64'h4009_21FB_5444_2D18, 0, 0, "R5 raw wide");
      do_read(5'd10, FMT_WORD, QNAN_WORD, 0, 0, "R7 word conflict");
   endtask

   task automatic t_adopt();
      do_reset();
      do_read(5'd8, FMT_WORD, 64'h0, 0, 0, "R5 adopt word");
      do_read(5'd8, FMT_SINGLE, QNAN_SINGLE, 0, 0, "R5 adopted tag conflicts");
      do_read(5'd9, FMT_RAW, 64'h0, 0, 0, "R5 raw keeps tag");
      do_read(5'd9, FMT_SINGLE, 64'h0, 0, 0, "R5 adopt single");
      do_read(5'd9, FMT_WORD, QNAN_WORD, 0, 0, "R6 after adopt");
   endtask

   task automatic t_narrow_pairs();
      do_reset();
      mode_wide = 1'b0;
      do_write(5'd4, FMT_DOUBLE, 64'h1122_3344_5566_7788, 0, 0, "R3 pair wr");
      do_read(5'd4, FMT_DOUBLE, 64'h1122_3344_5566_7788, 0, 0, "R3 pair rd");
      do_read(5'd5, FMT_SINGLE, QNAN_SINGLE, 0, 0, "R9 partner tag double");
      do_write(5'd6, FMT_SINGLE, 64'hFFFF_FFFF_CAFE_F00D, 0, 0, "R3 wr lo");
      do_write(5'd7, FMT_SINGLE, 64'h0000_0000_0BAD_BEEF, 0, 0, "R3 wr hi");
      do_read(5'd6, FMT_RAW, 64'h0BAD_BEEF_CAFE_F00D, 0, 0, "R3 raw pair");
      do_read(5'd6, FMT_SINGLE, 64'h0000_0000_CAFE_F00D, 0, 0, "R2 narrow single");
   endtask

   task automatic t_odd_access();
      do_reset();
      mode_wide = 1'b0;
      do_write(5'd12, FMT_SINGLE, 64'h1111_1111, 0, 0, "R4 setup 12");
      do_write(5'd13, FMT_SINGLE, 64'h2222_2222, 0, 0, "R4 setup 13");
      do_write(5'd13, FMT_DOUBLE, 64'h3333_3333_4444_4444, 1, 0, "R4 odd write");
      do_read(5'd13, FMT_SINGLE, QNAN_SINGLE, 0, 0, "R4 odd poisoned");
      do_read(5'd14, FMT_WORD, QNAN_WORD, 0, 0, "R4 next poisoned");
      do_read(5'd12, FMT_SINGLE, 64'h1111_1111, 0, 0, "R4 even untouched");
      do_read(5'd15, FMT_DOUBLE, 64'h0, 1, 0, "R4 odd read");
      do_write(5'd31, FMT_LONG, 64'h5, 1, 0, "R4 last odd write");
      do_read(5'd31, FMT_SINGLE, QNAN_SINGLE, 0, 0, "R4 last poisoned");
      do_read(5'd0, FMT_SINGLE, 64'h0, 0, 0, "R4 no wrap to 0");
   endtask

   task automatic t_same_cycle();
      do_reset();
      mode_wide = 1'b1;
      do_write(5'd20, FMT_LONG, 64'h5555_5555_5555_5555, 0, 0, "R10 setup");
      @(negedge clk);
      rd_en = 1'b1; rd_idx = 5'd20; rd_fmt = FMT_LONG;
      wr_en = 1'b1; wr_idx = 5'd20; wr_fmt = FMT_LONG; wr_data = 64'hAAAA_AAAA_AAAA_AAAA;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      chk("R10 old data", rd_data, 64'h5555_5555_5555_5555);
      do_read(5'd20, FMT_LONG, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, "R10 new data");
      @(negedge clk);
      rd_en = 1'b1; rd_idx = 5'd21; rd_fmt = FMT_SINGLE;
      wr_en = 1'b1; wr_idx = 5'd21; wr_fmt = FMT_LONG; wr_data = 64'h77;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      do_read(5'd21, FMT_LONG, 64'h77, 0, 0, "R10 write tag wins");
   endtask

   task automatic t_bad_format();
      do_write(5'd20, 3'd5, 64'h9999, 0, 1, "R11 bad write");
      do_read(5'd20, FMT_LONG, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, "R11 unchanged");
      do_read(5'd20, 3'd6, 64'h0, 0, 1, "R11 bad read");
      do_read(5'd20, FMT_LONG, 64'hAAAA_AAAA_AAAA_AAAA, 0, 0, "R11 tag kept");
      @(negedge clk);
      chk("R11 fault clears", 64'(fmt_fault), 64'd0);
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_wide_single();
      t_adopt();
      t_narrow_pairs();
      t_odd_access();
      t_same_cycle();
      t_bad_format();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule